// File: doc/BRIEF.md
# Banked Pin Controller with Edge Capture

This block is a memory-mapped general-purpose pin controller. Pins are grouped into banks of 32. Each bank has its own set of word registers:

- a read-only level view of the pins;
- a direction register;
- a set port and a clear port that change the output latch bit by bit, with no read-modify-write;
- a rising-edge enable and a falling-edge enable;
- a sticky edge status.

Three banks share each 64-word page of the word address space. They are interleaved one word apart, so all the level registers of a page sit next to each other, then all the direction registers, and so on.

Every pin input passes through a two-flop synchronizer. One more flop holds the previous synchronized value, and comparing the two gives the edges. An enabled edge sets its status bit, and the bit stays set until software writes a one to it. The status bits of all banks are ORed onto a single interrupt line. A parameter mask marks pins whose direction bit has inverted sense.

Top module: `pin_bank_ctrl`

## Requirements
- R1: Addresses are word addresses. Bank n has its base at word ((n/3)*64 + n%3). Relative to a bank base, the registers sit at these word offsets: level +0, direction +3, set +6, clear +9, rise enable +12, fall enable +15, status +18.
- R2: Writing the set register forces to 1 every output latch bit whose data bit is 1. Bits written with 0 keep their value.
- R3: Writing the clear register forces to 0 every output latch bit whose data bit is 1. Bits written with 0 keep their value.
- R4: For an ordinary pin, direction bit 1 makes the pin an output (`pin_oe` high). For a pin whose bit is set in DIR_INV_MASK, direction bit 0 makes it an output and 1 makes it an input.
- R5: The level register returns `pin_in` as seen through the two-flop synchronizer, whatever the direction. A pin driven by the block therefore reads back its output value.
- R6: The rise and fall enables act independently per pin. A pin with both enables set captures either transition, and a pin with only one enable set ignores the other transition.
- R7: A status bit goes to 1 on an enabled edge and holds there. Writing 1 to a status bit clears it, writing 0 leaves it alone, and writing all ones clears the whole bank.
- R8: If an enabled edge and a write-one-to-clear hit the same status bit in the same cycle, the bit stays 1.
- R9: `irq` is high exactly while any status bit in any bank is 1, and it stays high until software clears those bits.
- R10: After reset, every pin is an input, the output latches are 0, both edge enables are 0 and the status is 0. For an inverted-sense pin the direction register therefore resets to 1.
- R11: Reads of unmapped words return 0 and writes to them change nothing. Unmapped words are: page offsets 21..63, bank slots at or above NUM_BANKS, and reads of the write-only set and clear registers.
- R12: A read asserted with `rd_en` in one cycle presents its data on `rdata` after the next rising clock edge. `rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS*32 | Pin input levels (asynchronous) |
| pin_out | output | NUM_BANKS*32 | Output latch values |
| pin_oe | output | NUM_BANKS*32 | Output enables |
| irq | output | 1 | OR of all status bits |

## Verification
The hardest case to reach from the ports is an enabled edge and a write-one-to-clear landing on the same status bit in the same cycle. The edge only becomes visible two clock edges after the pin changes. The bench therefore toggles the pin, counts exactly two rising edges, and then issues the clear so that it is registered on the same edge that captures the new transition. It then reads the status back and expects the bit to still be set. Readback of a driven output is checked through a bench-side pad model that loops `pin_out` back to `pin_in` wherever `pin_oe` is high.

// File: rtl/pin_bank_pkg.sv
// Package: shared constants and register index type for the pin controller.
package pin_bank_pkg;
    localparam int BANK_PINS = 32;
    localparam int MAX_BANKS = 7;
    localparam int SLOTS_PER_PAGE = 3;
    localparam int PAGE_WORDS_LOG2 = 6;
    localparam int REG_COUNT = 7;

    // Register index inside a bank; word offset = index * SLOTS_PER_PAGE.
    typedef enum logic [2:0] {
        REG_LEVEL = 3'd0,
        REG_DIR   = 3'd1,
        REG_SET   = 3'd2,
        REG_CLR   = 3'd3,
        REG_RISE  = 3'd4,
        REG_FALL  = 3'd5,
        REG_STAT  = 3'd6
    } reg_idx_t;
endpackage

// File: rtl/pin_addr_decode.sv
// Module: pin_addr_decode
// Splits a word address into bank number and register index.
// Assumes three bank slots per 64-word page; slot = offset mod 3,
// register = offset div 3. Offsets 21..63 and banks >= NUM_BANKS are unmapped.
module pin_addr_decode
    import pin_bank_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [2:0]        bank_idx,
    output reg_idx_t          reg_idx
);
    localparam int PAGE_W = ADDR_W - PAGE_WORDS_LOG2;
    localparam int MAP_WORDS = REG_COUNT * SLOTS_PER_PAGE;

    logic [5:0]        offs;
    logic [PAGE_W-1:0] page;
    logic [31:0]       bank_n;

    // Purpose: arithmetic split of the word address.
    always_comb begin
        offs     = addr[PAGE_WORDS_LOG2-1:0];
        page     = addr[ADDR_W-1:PAGE_WORDS_LOG2];
        bank_n   = 32'(page) * 32'(SLOTS_PER_PAGE) + 32'(offs % 6'(SLOTS_PER_PAGE));
        reg_idx  = reg_idx_t'(3'(offs / 6'(SLOTS_PER_PAGE)));
        bank_idx = 3'(bank_n);
        hit      = (32'(offs) < 32'(MAP_WORDS)) && (bank_n < 32'(NUM_BANKS));
    end
endmodule

// File: rtl/pin_bank.sv
// Module: pin_bank
// One 32-pin bank: output latch with set/clear ports, direction,
// synchronizer, edge detector, sticky status. Assumes the caller
// asserts we only for addresses decoded to this bank.
module pin_bank
    import pin_bank_pkg::*;
#(
    parameter logic [BANK_PINS-1:0] INV_MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  reg_idx_t             reg_idx,
    input  logic [31:0]          wdata,
    input  logic [BANK_PINS-1:0] pins,
    output logic [31:0]          rd_val,
    output logic [BANK_PINS-1:0] out_q,
    output logic [BANK_PINS-1:0] oe,
    output logic                 pend
);
    logic [BANK_PINS-1:0] sync1, sync2, prev;
    logic [BANK_PINS-1:0] dir_q, rise_q, fall_q, stat_q;
    logic [BANK_PINS-1:0] edge_hit, stat_clr;

    // Purpose: two-flop synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= pins;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Purpose: enabled edges from the synchronized stream.
    always_comb begin
        edge_hit = (sync2 & ~prev & rise_q) | (~sync2 & prev & fall_q);
        stat_clr = (we && reg_idx == REG_STAT) ? wdata : '0;
    end

    // Purpose: configuration registers and output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= INV_MASK;
            rise_q <= '0;
            fall_q <= '0;
        end else if (we) begin
            case (reg_idx)
                REG_DIR:  dir_q  <= wdata;
                REG_SET:  out_q  <= out_q | wdata;
                REG_CLR:  out_q  <= out_q & ~wdata;
                REG_RISE: rise_q <= wdata;
                REG_FALL: fall_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: sticky status; a new edge beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | edge_hit;
    end

    // Purpose: read mux; set and clear ports read as zero.
    always_comb begin
        case (reg_idx)
            REG_LEVEL: rd_val = sync2;
            REG_DIR:   rd_val = dir_q;
            REG_RISE:  rd_val = rise_q;
            REG_FALL:  rd_val = fall_q;
            REG_STAT:  rd_val = stat_q;
            default:   rd_val = '0;
        endcase
    end

    assign oe   = dir_q ^ INV_MASK;
    assign pend = |stat_q;

    assert_set_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && reg_idx == REG_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));
    assert_clr_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && reg_idx == REG_CLR) |=> ((out_q & $past(wdata)) == '0));
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && reg_idx == REG_STAT) |=> ((stat_q & $past(wdata & ~edge_hit)) == '0));
    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && pend) |=> pend);
endmodule

// File: rtl/pin_bank_ctrl.sv
// Module: pin_bank_ctrl (top)
// Banked pin controller: decodes the word address, instantiates NUM_BANKS
// banks, registers read data, and ORs bank pending flags onto irq.
// Assumes NUM_BANKS in 1..7 and ADDR_W large enough for the used pages.
module pin_bank_ctrl
    import pin_bank_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 10,
    parameter logic [MAX_BANKS*BANK_PINS-1:0] DIR_INV_MASK = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata,
    input  logic [NUM_BANKS*BANK_PINS-1:0] pin_in,
    output logic [NUM_BANKS*BANK_PINS-1:0] pin_out,
    output logic [NUM_BANKS*BANK_PINS-1:0] pin_oe,
    output logic                           irq
);
    logic        hit;
    logic [2:0]  bank_idx;
    reg_idx_t    reg_idx;
    logic [NUM_BANKS-1:0] bank_we, bank_pend;
    logic [31:0] bank_rd [NUM_BANKS];
    logic [31:0] rd_mux;

    pin_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .hit(hit), .bank_idx(bank_idx), .reg_idx(reg_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_we[b] = wr_en && hit && (bank_idx == 3'(b));
        pin_bank #(.INV_MASK(DIR_INV_MASK[b*BANK_PINS +: BANK_PINS])) u_bank (
            .clk(clk), .rst_n(rst_n), .we(bank_we[b]), .reg_idx(reg_idx),
            .wdata(wdata), .pins(pin_in[b*BANK_PINS +: BANK_PINS]),
            .rd_val(bank_rd[b]), .out_q(pin_out[b*BANK_PINS +: BANK_PINS]),
            .oe(pin_oe[b*BANK_PINS +: BANK_PINS]), .pend(bank_pend[b])
        );
    end

    // Purpose: pick the addressed bank's read value, zero when unmapped.
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (hit && bank_idx == 3'(b)) rd_mux = bank_rd[b];
    end

    // Purpose: one-cycle registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq = |bank_pend;

    assert_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(pin_out) && $stable(pin_oe));
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);
    assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_pin_bank_ctrl.sv
// Scoreboard bench: read tasks push expected words, a monitor pops and compares.
module test_pin_bank_ctrl;
    localparam int NB = 3;
    localparam int NP = NB * 32;
    localparam int AW = 10;
    localparam logic [223:0] INV = 224'(1) << 37;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [NP-1:0] pin_in, pin_out, pin_oe, ext = '0;
    logic irq;
    int checks = 0, errors = 0;
    logic rd_q = 0;
    bit done = 0;

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    // pad model: driven pins loop back
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    pin_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .DIR_INV_MASK(INV)) i_pin_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [AW-1:0] wa(int bank, int roff);
        return AW'((bank / 3) * 64 + bank % 3 + roff);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
        exp_t e;
        @(negedge clk);
        e.exp = exp; e.tag = tag;
        sb.push_back(e);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0;
    endtask

    always @(posedge clk) rd_q <= rd_en;

    // monitor: data is due one edge after rd_en (R12)
    always @(negedge clk) begin
        if (rd_q) begin
            exp_t e;
            if (sb.size() == 0) check("R12 unexpected read", rdata, 32'hx);
            else begin
                e = sb.pop_front();
                check({e.tag, " R12"}, rdata, e.exp);
            end
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check("R10 pin_oe", 32'(pin_oe != '0), 0);
        check("R10 pin_out", 32'(pin_out != '0), 0);
        check("R10 irq", 32'(irq), 0);
        rd(wa(0, 3), 32'h0, "R10 dir b0");
        rd(wa(1, 3), 32'h20, "R10 R4 inverted dir b1");
        // R2 / R3 / R4
        wr(wa(0, 6), 32'h0000_00F0);
        wr(wa(0, 3), 32'h0000_00FF);
        @(negedge clk);
        check("R2 set", pin_out[31:0], 32'h0000_00F0);
        check("R4 oe", pin_oe[31:0], 32'h0000_00FF);
        wr(wa(0, 9), 32'h0000_0030);
        @(negedge clk);
        check("R3 clear", pin_out[31:0], 32'h0000_00C0);
        wr(wa(0, 6), 32'h0);
        @(negedge clk);
        check("R2 zero write", pin_out[31:0], 32'h0000_00C0);
        // R5 level readback
        ext[31:0] = 32'h1234_5600;
        settle();
        rd(wa(0, 0), 32'h1234_56C0, "R5 level");
        // R4 inverted pin
        wr(wa(1, 3), 32'h0);
        @(negedge clk);
        check("R4 inverted oe", pin_oe[63:32], 32'h0000_0020);
        // R1 addressing of bank 1 rise register
        wr(wa(1, 12), 32'hFFFF_0000);
        rd(wa(1, 12), 32'hFFFF_0000, "R1 b1 rise");
        rd(wa(0, 12), 32'h0, "R1 b0 rise");
        wr(wa(1, 12), 32'h0);
        // R6 / R7 / R9 on bank 2
        wr(wa(2, 12), 32'h5);
        wr(wa(2, 15), 32'h6);
        ext[64] = 1; settle();
        rd(wa(2, 18), 32'h1, "R6 rise bit0");
        check("R9 irq set", 32'(irq), 1);
        ext[65] = 1; settle();
        rd(wa(2, 18), 32'h1, "R6 rise ignored on fall-only");
        ext[65] = 0; settle();
        ext[66] = 1; settle();
        ext[66] = 0; settle();
        rd(wa(2, 18), 32'h7, "R6 both edges");
        wr(wa(2, 18), 32'h1);
        rd(wa(2, 18), 32'h6, "R7 w1c one bit");
        check("R9 irq held", 32'(irq), 1);
        wr(wa(2, 18), 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9 irq cleared", 32'(irq), 0);
        rd(wa(2, 18), 32'h0, "R7 clear all");
        // R8 collision: edge captured on same edge as clear
        ext[64] = 0; settle();
        rd(wa(2, 18), 32'h0, "R8 pre");
        @(negedge clk); ext[64] = 1;
        @(posedge clk); @(posedge clk);
        wr(wa(2, 18), 32'h1);
        rd(wa(2, 18), 32'h1, "R8 edge wins");
        wr(wa(2, 18), 32'hFFFF_FFFF);
        // R11 unmapped
        wr(AW'(64 + 6), 32'hFFFF_FFFF);
        wr(AW'(21), 32'hFFFF_FFFF);
        @(negedge clk);
        check("R11 out unchanged", 32'(pin_out != NP'(32'h0000_00C0)), 0);
        rd(AW'(64 + 3), 32'h0, "R11 bank slot beyond count");
        rd(AW'(21), 32'h0, "R11 page offset 21");
        rd(wa(0, 6), 32'h0, "R11 set reads zero");
        rd(wa(0, 9), 32'h0, "R11 clear reads zero");
        repeat (3) @(negedge clk);
        check("R12 scoreboard drained", 32'(sb.size()), 0);
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule